// File: doc/BRIEF.md
# Banked Memory Interface Glue

This block sits between a multiplexed processor bus and a 16-bit memory built from two byte-wide banks, an upper bank on data bits 15:8 and a lower bank on bits 7:0. It takes the address and the active-low high-byte select, lets them pass while the address strobe is high and keeps them once the strobe falls. From the kept value it drives the halfword address for both banks and eight active-low chip selects decoded from the top three address bits. It also forms separate read and write strobes for each bank.

The bank strobes are built from the processor's active-low read and write commands, address bit 0 and the high-byte select. A word access drives both banks at once. A byte access drives only the bank that holds the addressed byte. The direction and enable lines of the data-bus transceiver pass through from the bus side.

The capture stage is a two-state machine. In `ST_OPEN` (address strobe high) the outputs follow the bus and the holding register loads on every clock edge. In `ST_HOLD` (address strobe low) the outputs show the holding register. The transition HOLD→OPEN is taken when the address strobe rises, and OPEN→HOLD when it falls. Reset enters `ST_HOLD`.

Top module: `membank_glue`

## Requirements
- R1: While `ale` is 1, `mem_addr` equals `bus_addr[16:1]` and `chip_en_n` reflects `bus_addr[19:17]` in the same cycle, with no clock edge needed.
- R2: While `ale` is 0, the outputs use the address and `bhe_n` captured at the last rising clock edge at which `ale` was 1. Later changes of `bus_addr` and `bhe_n` have no effect.
- R3: After reset, before any capture, the held address is 0 with bit 0 set and the held `bhe_n` is 1. As a result, `chip_en_n` is 8'hFE and no bank strobe goes low, whatever the commands are.
- R4: Exactly one bit of `chip_en_n` is 0: bit k, where k is the held address bits 19:17 read as an unsigned number.
- R5: `mem_addr` is the held address bits 16:1.
- R6: `wr_hi_n` is `wr_cmd_n` OR the held `bhe_n`. `wr_lo_n` is `wr_cmd_n` OR held address bit 0.
- R7: `rd_hi_n` is `rd_cmd_n` OR the held `bhe_n`. `rd_lo_n` is `rd_cmd_n` OR held address bit 0.
- R8: These are the bank selections, given as (held `bhe_n`, held bit 0). (0,0) is a word access and enables both banks. (0,1) is an odd byte and enables the upper bank only. (1,0) is an even byte and enables the lower bank only. (1,1) enables no bank.
- R9: `xcvr_dir` equals `dir_in` (0 = memory to processor, 1 = processor to memory), and `xcvr_en_n` equals `den_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding register |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address strobe: high = transparent, low = hold |
| bus_addr | input | 20 | Address from the multiplexed bus |
| bhe_n | input | 1 | Active-low high-byte select from the bus |
| rd_cmd_n | input | 1 | Active-low read command |
| wr_cmd_n | input | 1 | Active-low write command |
| dir_in | input | 1 | Transfer direction from the bus side |
| den_n | input | 1 | Active-low data enable from the bus side |
| mem_addr | output | 16 | Halfword address to both banks |
| chip_en_n | output | 8 | Active-low chip selects |
| wr_hi_n | output | 1 | Upper bank write strobe, active low |
| wr_lo_n | output | 1 | Lower bank write strobe, active low |
| rd_hi_n | output | 1 | Upper bank read strobe, active low |
| rd_lo_n | output | 1 | Lower bank read strobe, active low |
| xcvr_dir | output | 1 | Transceiver direction |
| xcvr_en_n | output | 1 | Transceiver enable, active low |

## Verification
The assertions check these rules on every cycle:
- the held address stays stable while the strobe stays low;
- the output tracks the bus while the strobe is high;
- exactly one chip select is active;
- no strobe goes low while its command is idle, or when the (1,1) bank combination is held.

The bench's scenarios show the rest:
- the reset value of the holding register;
- that the value kept is the one from the last edge with the strobe high, despite later bus activity;
- the decoding of each of the eight select codes;
- the upper and lower strobe patterns for every bank combination and each command;
- the pass-through of the transceiver controls.

// File: rtl/mbg_pkg.sv
package mbg_pkg;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_OPEN = 1'b1
    } hold_state_t;

    typedef struct packed {
        logic hi_n;
        logic lo_n;
    } bank_pair_t;

endpackage

// File: rtl/addr_hold.sv
module addr_hold
    import mbg_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ale,
    input  logic [W-1:0] addr_in,
    input  logic         bhe_in_n,
    output logic [W-1:0] addr_q,
    output logic         bhe_q_n
);

    localparam logic [W-1:0] RST_ADDR = {{(W-1){1'b0}}, 1'b1};

    hold_state_t  state_q, state_d;
    logic         capture;
    logic [W-1:0] held_addr;
    logic         held_bhe_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // next state and capture control
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_HOLD: if (ale) state_d = ST_OPEN;
            ST_OPEN: if (!ale) state_d = ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
        if (state_d == ST_OPEN) capture = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_addr  <= RST_ADDR;
            held_bhe_n <= 1'b1;
        end else if (capture) begin
            held_addr  <= addr_in;
            held_bhe_n <= bhe_in_n;
        end
    end

    assign addr_q  = ale ? addr_in  : held_addr;
    assign bhe_q_n = ale ? bhe_in_n : held_bhe_n;

    // R2: nothing moves while the strobe stays low
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale) |=> (ale || ($stable(addr_q) && $stable(bhe_q_n))));

    // R1: transparent while the strobe is high
    a_r1_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (addr_q == addr_in && bhe_q_n == bhe_in_n));

endmodule

// File: rtl/cs_decode.sv
module cs_decode #(
    parameter int SEL_W = 3,
    localparam int NUM = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [NUM-1:0]   ce_n
);

    for (genvar k = 0; k < NUM; k++) begin : g_ce
        assign ce_n[k] = (sel != SEL_W'(k));
    end

endmodule

// File: rtl/bank_strobe.sv
module bank_strobe
    import mbg_pkg::*;
(
    input  logic       cmd_n,
    input  logic       bhe_n,
    input  logic       a0,
    output bank_pair_t strobe
);

    always_comb begin
        strobe.hi_n = cmd_n | bhe_n;
        strobe.lo_n = cmd_n | a0;
    end

endmodule

// File: rtl/membank_glue.sv
module membank_glue
    import mbg_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int SEL_W  = 3,
    localparam int MEM_W  = ADDR_W - SEL_W - 1,
    localparam int NUM_CE = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bhe_n,
    input  logic              rd_cmd_n,
    input  logic              wr_cmd_n,
    input  logic              dir_in,
    input  logic              den_n,
    output logic [MEM_W-1:0]  mem_addr,
    output logic [NUM_CE-1:0] chip_en_n,
    output logic              wr_hi_n,
    output logic              wr_lo_n,
    output logic              rd_hi_n,
    output logic              rd_lo_n,
    output logic              xcvr_dir,
    output logic              xcvr_en_n
);

    logic [ADDR_W-1:0] lat_addr;
    logic              lat_bhe_n;
    bank_pair_t        wr_pair, rd_pair;

    addr_hold #(.W(ADDR_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (ale),
        .addr_in  (bus_addr),
        .bhe_in_n (bhe_n),
        .addr_q   (lat_addr),
        .bhe_q_n  (lat_bhe_n)
    );

    cs_decode #(.SEL_W(SEL_W)) u_dec (
        .sel  (lat_addr[ADDR_W-1 -: SEL_W]),
        .ce_n (chip_en_n)
    );

    bank_strobe u_wr (
        .cmd_n  (wr_cmd_n),
        .bhe_n  (lat_bhe_n),
        .a0     (lat_addr[0]),
        .strobe (wr_pair)
    );

    bank_strobe u_rd (
        .cmd_n  (rd_cmd_n),
        .bhe_n  (lat_bhe_n),
        .a0     (lat_addr[0]),
        .strobe (rd_pair)
    );

    assign mem_addr  = lat_addr[MEM_W:1];
    assign wr_hi_n   = wr_pair.hi_n;
    assign wr_lo_n   = wr_pair.lo_n;
    assign rd_hi_n   = rd_pair.hi_n;
    assign rd_lo_n   = rd_pair.lo_n;
    assign xcvr_dir  = dir_in;
    assign xcvr_en_n = den_n;

    // R4: one chip select active
    a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~chip_en_n) == 1);

    // R1: halfword address tracks the bus while transparent
    a_r1_mem_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (mem_addr == bus_addr[MEM_W:1]));

    // R6: idle write command keeps both write strobes high
    a_r6_wr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd_n |-> (wr_hi_n && wr_lo_n));

    // R7: idle read command keeps both read strobes high
    a_r7_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_n |-> (rd_hi_n && rd_lo_n));

    // R8: combination (1,1) selects no bank
    a_r8_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_bhe_n && lat_addr[0]) |-> (wr_hi_n && wr_lo_n && rd_hi_n && rd_lo_n));

endmodule

// File: tb/membank_glue_test.sv
module membank_glue_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ale;
    logic [19:0] bus_addr;
    logic        bhe_n, rd_cmd_n, wr_cmd_n, dir_in, den_n;
    logic [15:0] mem_addr;
    logic [7:0]  chip_en_n;
    logic        wr_hi_n, wr_lo_n, rd_hi_n, rd_lo_n, xcvr_dir, xcvr_en_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    membank_glue uut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .bus_addr(bus_addr), .bhe_n(bhe_n),
        .rd_cmd_n(rd_cmd_n), .wr_cmd_n(wr_cmd_n), .dir_in(dir_in), .den_n(den_n),
        .mem_addr(mem_addr), .chip_en_n(chip_en_n), .wr_hi_n(wr_hi_n),
        .wr_lo_n(wr_lo_n), .rd_hi_n(rd_hi_n), .rd_lo_n(rd_lo_n),
        .xcvr_dir(xcvr_dir), .xcvr_en_n(xcvr_en_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ce_exp(input logic [19:0] a);
        return ~(8'b1 << a[19:17]);
    endfunction

    task automatic capture(input logic [19:0] a, input logic b);
        @(negedge clk);
        ale = 1'b1; bus_addr = a; bhe_n = b;
        @(posedge clk);
        @(negedge clk);
        ale = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; ale = 1'b0; bus_addr = 20'hF_FFFF; bhe_n = 1'b0;
        rd_cmd_n = 1'b0; wr_cmd_n = 1'b0; dir_in = 1'b0; den_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R3 chip_en_n at reset", 32'(chip_en_n), 32'hFE);
        chk("R3 strobes at reset", {wr_hi_n, wr_lo_n, rd_hi_n, rd_lo_n}, 4'hF);
        chk("R3 mem_addr at reset", 32'(mem_addr), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R3 strobes after release", {wr_hi_n, wr_lo_n, rd_hi_n, rd_lo_n}, 4'hF);
        rd_cmd_n = 1'b1; wr_cmd_n = 1'b1;
    endtask

    task automatic t_transparent;
        @(negedge clk);
        ale = 1'b1; bus_addr = 20'hA_BCDE; bhe_n = 1'b0;
        #1;
        chk("R1 mem_addr follows", 32'(mem_addr), 32'(bus_addr[16:1]));
        chk("R1 chip_en_n follows", 32'(chip_en_n), 32'(ce_exp(bus_addr)));
        #1;
        bus_addr = 20'h3_0F0E;
        #1;
        chk("R1 mem_addr follows change", 32'(mem_addr), 32'h8787);
        chk("R1 chip_en_n follows change", 32'(chip_en_n), 32'(ce_exp(20'h3_0F0E)));
        @(negedge clk);
        ale = 1'b0;
    endtask

    task automatic t_hold;
        capture(20'h6_2468, 1'b0);
        bus_addr = 20'h1_1111; bhe_n = 1'b1;
        #1;
        chk("R2 mem_addr held", 32'(mem_addr), 32'h1234);
        chk("R2 chip_en_n held", 32'(chip_en_n), 32'(ce_exp(20'h6_2468)));
        wr_cmd_n = 1'b0;
        #1;
        chk("R2 bhe held (write pair)", {wr_hi_n, wr_lo_n}, 2'b00);
        wr_cmd_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_addr = 20'hF_FFFF;
        #1;
        chk("R2 mem_addr held over cycles", 32'(mem_addr), 32'h1234);
    endtask

    task automatic t_decode;
        for (int s = 0; s < 8; s++) begin
            logic [19:0] a;
            a = {3'(s), 17'h0_5A5A};
            capture(a, 1'b1);
            chk("R4 chip select decode", 32'(chip_en_n), 32'(ce_exp(a)));
            chk("R5 halfword address", 32'(mem_addr), 32'(a[16:1]));
        end
    endtask

    task automatic t_strobes;
        for (int c = 0; c < 4; c++) begin
            logic b, z;
            logic [1:0] exp_pair;
            b = c[1]; z = c[0];
            capture({3'd2, 16'h00C3, z}, b);
            exp_pair = {b, z};
            wr_cmd_n = 1'b0; rd_cmd_n = 1'b1;
            #1;
            chk("R6 R8 write pair", {wr_hi_n, wr_lo_n}, exp_pair);
            chk("R7 read idle during write", {rd_hi_n, rd_lo_n}, 2'b11);
            wr_cmd_n = 1'b1; rd_cmd_n = 1'b0;
            #1;
            chk("R7 R8 read pair", {rd_hi_n, rd_lo_n}, exp_pair);
            chk("R6 write idle during read", {wr_hi_n, wr_lo_n}, 2'b11);
            rd_cmd_n = 1'b1;
            #1;
        end
    endtask

    task automatic t_xcvr;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            dir_in = c[0]; den_n = c[1];
            #1;
            chk("R9 transceiver controls", {xcvr_dir, xcvr_en_n}, {c[0], c[1]});
        end
    endtask

    initial begin
        t_reset;
        t_transparent;
        t_hold;
        t_decode;
        t_strobes;
        t_xcvr;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule